// File: doc/BRIEF.md
# UART Register, Command and Interrupt Controller

This block is the bus-facing control core of a simple UART. It decodes a 64-byte register window and holds the mode registers, the status byte, the interrupt status and the interrupt mask. It carries out command-register writes and holds a single transmit byte, which it offers to an external serial transmitter over a valid/ready handshake. All interrupt sources are masked and merged onto one request line.

The receive FIFO sits outside the block. The core sees its head byte and its non-empty and full flags. It pops the FIFO when software reads the receive buffer, and it flushes the FIFO on a receiver reset. Error conditions and break detections reported by the receive path are latched here. The baud generator, the shifters and the break generation are not part of this block.

Top module: `uart_ctrl_core`

## Requirements
- R1: After reset, the status byte reads 0x08 (transmitter empty only), the transmitter and receiver are disabled, the mask is 0x00, all mode registers are 0x00, the mode pointer selects mode register 1, and `irq`, `tx_valid`, `rx_enable` and `rxf_pop` are low.
- R2: Status byte (offset 0x04) bits: 0 = FIFO non-empty (receiver ready), 1 = FIFO full, 2 = transmitter enabled (transmitter ready), 3 = transmitter empty, 4 = overrun, 5 = parity error, 6 = framing error, 7 = received break. Bits 4..7 are sticky copies of `rx_err_set[0..3]` and are cleared by miscellaneous command 4.
- R3: The interrupt status byte (read at offset 0x14) has bit 0 equal to status bit 2. Bit 1 equals status bit 1 when mode register 1 bit 6 is set, and status bit 0 when that bit is clear. Bit 2 is set by a `rx_brk_evt` pulse and cleared by miscellaneous command 5. Bit 7 reads 0.
- R4: `irq` is high exactly when the interrupt status AND the mask (offset 0x10, read/write) is nonzero. A mask write changes `irq` from the cycle after the write.
- R5: Only the low 6 address bits are decoded. Offset 0x00 is the mode register, 0x08 is the command register (write), and 0x0C is the transmit buffer on write and the receive buffer on read. Reads of any other offset return 0x00.
- R6: An access to offset 0x00 reads or writes the mode register chosen by the pointer. Each such access then advances the pointer from mode register 1 to mode register 2, where it stays until miscellaneous command 1 returns it to mode register 1.
- R7: A read of offset 0x0C returns `rxf_data` and raises `rxf_pop` for that one cycle only if `rxf_nonempty` is high. A read with the FIFO empty does not pop.
- R8: Command bits [6:4] select a miscellaneous command. Code 2 disables the receiver and pulses `rxf_flush`. Code 3 sets transmitter-empty, discarding the held byte, and disables the transmitter. Codes 0, 6 and 7 change no state.
- R9: Command bits [3:2] control the transmitter and bits [1:0] control the receiver: 1 enables, 2 disables, and 0 and 3 leave the state unchanged. `rx_enable` shows the receiver state.
- R10: A write to the transmit buffer clears transmitter-empty. `tx_valid` is high while the transmitter is enabled and a byte is held. When `tx_valid` and `tx_ready` are both high, the byte is handed off and transmitter-empty is set on the next cycle.
- R11: When one command byte carries both a reset (code 2 or 3) and an enable, the reset is applied first, so the unit ends up enabled. For the transmitter the held byte is also discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_ADDR_W | Byte offset; low 6 bits decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| rxf_data | input | DATA_W | Head byte of the external receive FIFO |
| rxf_nonempty | input | 1 | Receive FIFO holds data |
| rxf_full | input | 1 | Receive FIFO is full |
| rxf_pop | output | 1 | Pop the receive FIFO head |
| rxf_flush | output | 1 | Empty the receive FIFO (receiver reset) |
| rx_err_set | input | 4 | Error pulses: overrun, parity, framing, break |
| rx_brk_evt | input | 1 | Break-change event pulse |
| rx_enable | output | 1 | Receiver enabled |
| tx_data | output | DATA_W | Held transmit byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume at most one register access per cycle. They also assume that `rxf_full` implies `rxf_nonempty`, and that the transmitter raises `tx_ready` only when it can take a byte. The stimulus holds each bus access for exactly one clock and keeps the FIFO flags consistent. It pulses the error and break inputs only between accesses, so a sticky set never meets its clear in the same cycle. `tx_ready` stays low except for a single deliberate handshake, so the held byte stays observable at the ports.

// File: rtl/uart_ctrl_pkg.sv
package uart_ctrl_pkg;

   // status byte bit positions
   localparam int SB_RXRDY = 0;
   localparam int SB_FULL  = 1;
   localparam int SB_TXRDY = 2;
   localparam int SB_TXEMP = 3;

   // interrupt status bit positions
   localparam int IB_TX   = 0;
   localparam int IB_RX   = 1;
   localparam int IB_DBRK = 2;

   // register offsets within the 64-byte window
   localparam logic [5:0] OFS_MODE  = 6'h00;
   localparam logic [5:0] OFS_STAT  = 6'h04;
   localparam logic [5:0] OFS_CMD   = 6'h08;
   localparam logic [5:0] OFS_DATA  = 6'h0C;
   localparam logic [5:0] OFS_MASK  = 6'h10;
   localparam logic [5:0] OFS_ISTAT = 6'h14;

   typedef enum logic [2:0] {
      MISC_NOP      = 3'd0,
      MISC_PTR_RST  = 3'd1,
      MISC_RX_RST   = 3'd2,
      MISC_TX_RST   = 3'd3,
      MISC_ERR_RST  = 3'd4,
      MISC_DBRK_CLR = 3'd5,
      MISC_BRK_ON   = 3'd6,
      MISC_BRK_OFF  = 3'd7
   } misc_e;

   typedef enum logic [1:0] {
      EN_KEEP = 2'd0,
      EN_ON   = 2'd1,
      EN_OFF  = 2'd2,
      EN_RSVD = 2'd3
   } en_cmd_e;

   typedef struct packed {
      logic ptr_rst;
      logic rx_rst;
      logic tx_rst;
      logic err_rst;
      logic dbrk_clr;
      logic tx_on;
      logic tx_off;
      logic rx_on;
      logic rx_off;
   } cmd_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
   import uart_ctrl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] cmd_byte,
   output cmd_t              cmd
);

   misc_e   misc;
   en_cmd_e tx_fld;
   en_cmd_e rx_fld;

   assign misc   = misc_e'(cmd_byte[6:4]);
   assign tx_fld = en_cmd_e'(cmd_byte[3:2]);
   assign rx_fld = en_cmd_e'(cmd_byte[1:0]);

   always_comb begin
      cmd = '0;
      if (cmd_wr) begin
         unique case (misc)
            MISC_PTR_RST:  cmd.ptr_rst  = 1'b1;
            MISC_RX_RST:   cmd.rx_rst   = 1'b1;
            MISC_TX_RST:   cmd.tx_rst   = 1'b1;
            MISC_ERR_RST:  cmd.err_rst  = 1'b1;
            MISC_DBRK_CLR: cmd.dbrk_clr = 1'b1;
            default:       ;  // nop, break start/stop: nothing held here
         endcase
         cmd.tx_on  = (tx_fld == EN_ON);
         cmd.tx_off = (tx_fld == EN_OFF);
         cmd.rx_on  = (rx_fld == EN_ON);
         cmd.rx_off = (rx_fld == EN_OFF);
      end
   end

   logic unused_cmd_bits;
   assign unused_cmd_bits = ^cmd_byte[DATA_W-1:7];

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tb_wr,
   input  logic [DATA_W-1:0] tb_wdata,
   input  logic              tx_rst,
   input  logic              tx_on,
   input  logic              tx_off,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              tx_en,
   output logic              tx_empty
);

   logic [DATA_W-1:0] data_q;
   logic              en_q;
   logic              empty_q;
   logic              en_nxt;
   logic              handoff;

   assign handoff = tx_valid && tx_ready;

   // reset field first, then the enable field of the same command
   always_comb begin
      en_nxt = en_q;
      if (tx_rst) en_nxt = 1'b0;
      if (tx_on)       en_nxt = 1'b1;
      else if (tx_off) en_nxt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         en_q    <= 1'b0;
         empty_q <= 1'b1;
      end else begin
         en_q <= en_nxt;
         if (tx_rst)       empty_q <= 1'b1;
         else if (tb_wr)   empty_q <= 1'b0;
         else if (handoff) empty_q <= 1'b1;
         if (tb_wr) data_q <= tb_wdata;
      end
   end

   assign tx_data  = data_q;
   assign tx_valid = en_q && !empty_q;
   assign tx_en    = en_q;
   assign tx_empty = empty_q;

   // R10: buffer write leaves a byte held
   a_r10_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_wr && !tx_rst) |=> !tx_empty);
   // R10: accepted byte frees the buffer
   a_r10_handoff_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && !tb_wr) |=> tx_empty);
   // R11: reset then enable leaves an enabled, empty transmitter
   a_r11_reset_then_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rst && tx_on) |=> (tx_en && tx_empty));

endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine
   import uart_ctrl_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] status,
   input  logic              rx_on_full,
   input  logic              dbrk_set,
   input  logic              dbrk_clr,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] isr,
   output logic              irq
);

   logic dbrk_q;
   logic irq_raw;

   always_ff @(posedge clk) begin
      if (!rst_n)        dbrk_q <= 1'b0;
      else if (dbrk_set) dbrk_q <= 1'b1;
      else if (dbrk_clr) dbrk_q <= 1'b0;
   end

   always_comb begin
      isr          = '0;
      isr[IB_TX]   = status[SB_TXRDY];
      isr[IB_RX]   = rx_on_full ? status[SB_FULL] : status[SB_RXRDY];
      isr[IB_DBRK] = dbrk_q;
   end

   assign irq_raw = |(isr & mask);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_direct
         assign irq = irq_raw;
      end
   endgenerate

   // R3: delta-break clear command empties the latch
   a_r3_dbrk_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (dbrk_clr && !dbrk_set) |=> !isr[IB_DBRK]);
   // R3: break event latches
   a_r3_dbrk_sets: assert property (@(posedge clk) disable iff (!rst_n)
      dbrk_set |=> isr[IB_DBRK]);

endmodule

// File: rtl/uart_ctrl_core.sv
module uart_ctrl_core
   import uart_ctrl_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int BUS_ADDR_W      = 8,
   parameter int NUM_MODE_REGS   = 2,
   parameter int RX_FULL_SEL_BIT = 6,
   parameter int ERR_W           = 4,
   parameter bit IRQ_REG         = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [BUS_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [DATA_W-1:0]     rxf_data,
   input  logic                  rxf_nonempty,
   input  logic                  rxf_full,
   output logic                  rxf_pop,
   output logic                  rxf_flush,
   input  logic [ERR_W-1:0]      rx_err_set,
   input  logic                  rx_brk_evt,
   output logic                  rx_enable,
   output logic [DATA_W-1:0]     tx_data,
   output logic                  tx_valid,
   input  logic                  tx_ready,
   output logic                  irq
);

   localparam int PTR_W   = (NUM_MODE_REGS > 1) ? $clog2(NUM_MODE_REGS) : 1;
   localparam int WIN_W   = 6;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_MODE_REGS - 1);

   // elaboration checks
   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("uart_ctrl_core: status layout needs DATA_W of 8");
      end
      if (BUS_ADDR_W < WIN_W) begin : g_bad_addr_w
         $error("uart_ctrl_core: BUS_ADDR_W must cover the 64-byte window");
      end
      if (NUM_MODE_REGS < 2) begin : g_bad_mr
         $error("uart_ctrl_core: at least two mode registers required");
      end
      if (RX_FULL_SEL_BIT >= DATA_W) begin : g_bad_sel
         $error("uart_ctrl_core: RX_FULL_SEL_BIT outside mode register");
      end
      if (ERR_W != 4) begin : g_bad_err
         $error("uart_ctrl_core: four error flags map to status bits 4..7");
      end
   endgenerate

   // ---------------------------------------------------------------
   // access decode
   // ---------------------------------------------------------------
   logic [WIN_W-1:0] ofs;
   logic             wr_acc;
   logic             rd_acc;
   logic             mode_acc;
   logic             cmd_wr;
   logic             tb_wr;
   logic             mask_wr;

   assign ofs      = bus_addr[WIN_W-1:0];
   assign wr_acc   = bus_sel && bus_wr;
   assign rd_acc   = bus_sel && !bus_wr;
   assign mode_acc = bus_sel && (ofs == OFS_MODE);
   assign cmd_wr   = wr_acc && (ofs == OFS_CMD);
   assign tb_wr    = wr_acc && (ofs == OFS_DATA);
   assign mask_wr  = wr_acc && (ofs == OFS_MASK);

   cmd_t cmd;

   uart_cmd_decode #(.DATA_W(DATA_W)) i_cmd_decode (
      .cmd_wr   (cmd_wr),
      .cmd_byte (bus_wdata),
      .cmd      (cmd)
   );

   // ---------------------------------------------------------------
   // mode register bank and pointer
   // ---------------------------------------------------------------
   logic [PTR_W-1:0]  ptr_q;
   logic [DATA_W-1:0] mode_q [NUM_MODE_REGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (cmd.ptr_rst) begin
         ptr_q <= '0;
      end else if (mode_acc && (ptr_q != PTR_LAST)) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < NUM_MODE_REGS; g++) begin : g_mode
         always_ff @(posedge clk) begin
            if (!rst_n)
               mode_q[g] <= '0;
            else if (wr_acc && mode_acc && (ptr_q == PTR_W'(g)))
               mode_q[g] <= bus_wdata;
         end
      end
   endgenerate

   // ---------------------------------------------------------------
   // receiver enable and sticky error flags
   // ---------------------------------------------------------------
   logic             rx_en_q;
   logic             rx_en_nxt;
   logic [ERR_W-1:0] err_q;

   always_comb begin
      rx_en_nxt = rx_en_q;
      if (cmd.rx_rst) rx_en_nxt = 1'b0;
      if (cmd.rx_on)       rx_en_nxt = 1'b1;
      else if (cmd.rx_off) rx_en_nxt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_en_q <= 1'b0;
         err_q   <= '0;
      end else begin
         rx_en_q <= rx_en_nxt;
         err_q   <= (cmd.err_rst ? '0 : err_q) | rx_err_set;
      end
   end

   assign rx_enable = rx_en_q;
   assign rxf_flush = cmd.rx_rst;
   assign rxf_pop   = rd_acc && (ofs == OFS_DATA) && rxf_nonempty;

   // ---------------------------------------------------------------
   // transmitter holding byte
   // ---------------------------------------------------------------
   logic tx_en;
   logic tx_empty;

   uart_tx_hold #(.DATA_W(DATA_W)) i_tx_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .tb_wr    (tb_wr),
      .tb_wdata (bus_wdata),
      .tx_rst   (cmd.tx_rst),
      .tx_on    (cmd.tx_on),
      .tx_off   (cmd.tx_off),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .tx_en    (tx_en),
      .tx_empty (tx_empty)
   );

   // ---------------------------------------------------------------
   // status, mask and interrupt
   // ---------------------------------------------------------------
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] isr;

   always_comb begin
      status           = '0;
      status[SB_RXRDY] = rxf_nonempty;
      status[SB_FULL]  = rxf_full;
      status[SB_TXRDY] = tx_en;
      status[SB_TXEMP] = tx_empty;
      status[7:4]      = err_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= bus_wdata;
   end

   uart_irq_combine #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) i_irq_combine (
      .clk        (clk),
      .rst_n      (rst_n),
      .status     (status),
      .rx_on_full (mode_q[0][RX_FULL_SEL_BIT]),
      .dbrk_set   (rx_brk_evt),
      .dbrk_clr   (cmd.dbrk_clr),
      .mask       (mask_q),
      .isr        (isr),
      .irq        (irq)
   );

   // ---------------------------------------------------------------
   // read mux
   // ---------------------------------------------------------------
   always_comb begin
      bus_rdata = '0;
      if (rd_acc) begin
         unique case (ofs)
            OFS_MODE:  bus_rdata = mode_q[ptr_q];
            OFS_STAT:  bus_rdata = status;
            OFS_DATA:  bus_rdata = rxf_data;
            OFS_MASK:  bus_rdata = mask_q;
            OFS_ISTAT: bus_rdata = isr;
            default:   bus_rdata = '0;
         endcase
      end
   end

   logic unused_addr_hi;
   assign unused_addr_hi = ^{1'b0, bus_addr[BUS_ADDR_W-1:WIN_W]};

   // ---------------------------------------------------------------
   // assertions
   // ---------------------------------------------------------------
   // R6: once on the last mode register the pointer holds
   a_r6_ptr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((ptr_q == PTR_LAST) && !cmd.ptr_rst) |=> (ptr_q == PTR_LAST));
   // R6: reset-pointer command returns to mode register 1
   a_r6_ptr_reset: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.ptr_rst |=> (ptr_q == '0));
   // R7: never pop an empty FIFO
   a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_pop |-> rxf_nonempty);
   // R9: a byte is offered only by an enabled transmitter
   a_r9_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> status[SB_TXRDY]);
   // R8: receiver reset without re-enable leaves the receiver off
   a_r8_rx_reset_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.rx_rst && !cmd.rx_on) |=> !rx_enable);
   generate
      if (!IRQ_REG) begin : g_irq_chk
         // R4: clearing the mask silences the request next cycle
         a_r4_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_wr && (bus_wdata == '0)) |=> !irq);
      end
   endgenerate

endmodule

// File: tb/test_uart_ctrl_core.sv
`timescale 1ns/1ps
module test_uart_ctrl_core;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] rxf_data = 8'hA5;
   logic       rxf_nonempty = 1'b0;
   logic       rxf_full = 1'b0;
   logic       rxf_pop;
   logic       rxf_flush;
   logic [3:0] rx_err_set = '0;
   logic       rx_brk_evt = 1'b0;
   logic       rx_enable;
   logic [7:0] tx_data;
   logic       tx_valid;
   logic       tx_ready = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uart_ctrl_core i_uart_ctrl_core (
      .clk (clk), .rst_n (rst_n),
      .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .rxf_data (rxf_data), .rxf_nonempty (rxf_nonempty), .rxf_full (rxf_full),
      .rxf_pop (rxf_pop), .rxf_flush (rxf_flush),
      .rx_err_set (rx_err_set), .rx_brk_evt (rx_brk_evt), .rx_enable (rx_enable),
      .tx_data (tx_data), .tx_valid (tx_valid), .tx_ready (tx_ready), .irq (irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one-cycle write; flush is captured inside the access cycle
   task automatic bus_write(input logic [7:0] a, input logic [7:0] d, output logic flush);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #2 flush = rxf_flush;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
      #2;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d, output logic pop);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2 d = bus_rdata; pop = rxf_pop;
      @(posedge clk);
      #1 bus_sel = 1'b0;
      #2;
   endtask

   typedef struct packed {
      logic       rd;
      logic [7:0] addr;
      logic [7:0] val;   // write data, or expected read data
      logic [3:0] req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h04, 8'h08, 4'd2},   // R2 status after reset
      '{1'b1, 8'h10, 8'h00, 4'd4},   // R4 mask reset
      '{1'b0, 8'h00, 8'h40, 4'd6},   // R6 write mode 1, pointer to 2
      '{1'b0, 8'h00, 8'h13, 4'd6},   // R6 write mode 2
      '{1'b1, 8'h00, 8'h13, 4'd6},   // R6 pointer stays on mode 2
      '{1'b0, 8'h08, 8'h10, 4'd6},   // R6 reset pointer
      '{1'b1, 8'h00, 8'h40, 4'd6},   // R6 mode 1 after reset
      '{1'b1, 8'h40, 8'h13, 4'd5},   // R5 alias of offset 0x00
      '{1'b1, 8'h1C, 8'h00, 4'd5},   // R5 unimplemented read
      '{1'b1, 8'h3C, 8'h00, 4'd5},   // R5 unimplemented read
      '{1'b0, 8'h08, 8'h05, 4'd9},   // R9 enable both
      '{1'b1, 8'h04, 8'h0C, 4'd9},   // R9 tx ready and empty
      '{1'b1, 8'h14, 8'h01, 4'd3},   // R3 tx interrupt
      '{1'b0, 8'h0C, 8'h5A, 4'd10},  // R10 load transmit byte
      '{1'b1, 8'h04, 8'h04, 4'd10},  // R10 empty cleared
      '{1'b0, 8'h08, 8'h08, 4'd9},   // R9 tx disable
      '{1'b1, 8'h04, 8'h00, 4'd9},
      '{1'b0, 8'h08, 8'h0C, 4'd9},   // R9 reserved code ignored
      '{1'b1, 8'h04, 8'h00, 4'd9},
      '{1'b0, 8'h08, 8'h34, 4'd11},  // R11 reset tx + enable tx
      '{1'b1, 8'h04, 8'h0C, 4'd11},
      '{1'b0, 8'h10, 8'h01, 4'd4},   // R4 mask write
      '{1'b1, 8'h10, 8'h01, 4'd4},
      '{1'b0, 8'h4C, 8'h77, 4'd5},   // R5 aliased transmit buffer
      '{1'b1, 8'h04, 8'h04, 4'd5},
      '{1'b0, 8'h08, 8'h60, 4'd8},   // R8 code 6 no effect
      '{1'b1, 8'h04, 8'h04, 4'd8},
      '{1'b0, 8'h08, 8'h30, 4'd8},   // R8 reset transmitter
      '{1'b1, 8'h04, 8'h08, 4'd8}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic       p;
      logic       f;

      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;
      // R1 reset state at the ports
      check("R1 irq", {7'd0, irq}, 8'h00);
      check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
      check("R1 rx_enable", {7'd0, rx_enable}, 8'h00);
      check("R1 rxf_pop", {7'd0, rxf_pop}, 8'h00);
      bus_read(8'h00, d, p);
      check("R1 mode 1 value", d, 8'h00);
      bus_write(8'h08, 8'h10, f);     // pointer back to mode 1

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rd) begin
            bus_read(VEC[i].addr, d, p);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), d, VEC[i].val);
         end else begin
            bus_write(VEC[i].addr, VEC[i].val, f);
         end
      end

      // R4: interrupt follows mask and source
      check("R4 irq idle", {7'd0, irq}, 8'h00);
      bus_write(8'h08, 8'h04, f);
      check("R4 irq on tx ready", {7'd0, irq}, 8'h01);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 8'h00;
      #2 check("R4 irq in write cycle", {7'd0, irq}, 8'h01);
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
      #2 check("R4 irq after mask clear", {7'd0, irq}, 8'h00);

      // R10: handshake hands the byte off
      bus_write(8'h0C, 8'h3C, f);
      check("R10 tx_valid", {7'd0, tx_valid}, 8'h01);
      check("R10 tx_data", tx_data, 8'h3C);
      @(negedge clk); tx_ready = 1'b1;
      @(posedge clk); #1 tx_ready = 1'b0;
      #2 check("R10 valid dropped", {7'd0, tx_valid}, 8'h00);
      bus_read(8'h04, d, p);
      check("R10 empty again", d, 8'h0C);

      // R7: receive buffer read and pop
      rxf_nonempty = 1'b1;
      bus_read(8'h0C, d, p);
      check("R7 rx data", d, 8'hA5);
      check("R7 pop", {7'd0, p}, 8'h01);
      check("R7 pop one cycle", {7'd0, rxf_pop}, 8'h00);
      rxf_nonempty = 1'b0;
      bus_read(8'h0C, d, p);
      check("R7 no pop when empty", {7'd0, p}, 8'h00);

      // R3: receive interrupt source selection (mode 1 bit 6 set)
      rxf_nonempty = 1'b1;
      bus_read(8'h14, d, p);
      check("R3 full mode, not full", d, 8'h01);
      rxf_full = 1'b1;
      bus_read(8'h14, d, p);
      check("R3 full mode, full", d, 8'h03);
      bus_read(8'h04, d, p);
      check("R2 fifo flags", d, 8'h0F);
      rxf_full = 1'b0;
      bus_write(8'h08, 8'h10, f);
      bus_write(8'h00, 8'h00, f);
      bus_read(8'h14, d, p);
      check("R3 ready mode", d, 8'h03);
      rxf_nonempty = 1'b0;

      // R2: sticky errors and their reset
      @(negedge clk); rx_err_set = 4'b1010;
      @(negedge clk); rx_err_set = 4'b0000;
      bus_read(8'h04, d, p);
      check("R2 sticky errors", d, 8'hAC);
      bus_write(8'h08, 8'h40, f);
      bus_read(8'h04, d, p);
      check("R2 error reset", d, 8'h0C);

      // R3: delta-break latch
      @(negedge clk); rx_brk_evt = 1'b1;
      @(negedge clk); rx_brk_evt = 1'b0;
      bus_read(8'h14, d, p);
      check("R3 break latched", d, 8'h05);
      bus_write(8'h08, 8'h50, f);
      bus_read(8'h14, d, p);
      check("R3 break cleared", d, 8'h01);

      // R8 / R9 / R11: receiver commands
      bus_write(8'h08, 8'h01, f);
      check("R9 rx enabled", {7'd0, rx_enable}, 8'h01);
      bus_write(8'h08, 8'h20, f);
      check("R8 flush pulse", {7'd0, f}, 8'h01);
      check("R8 rx disabled", {7'd0, rx_enable}, 8'h00);
      check("R8 flush one cycle", {7'd0, rxf_flush}, 8'h00);
      bus_write(8'h08, 8'h21, f);
      check("R11 flush with enable", {7'd0, f}, 8'h01);
      check("R11 rx enabled after reset", {7'd0, rx_enable}, 8'h01);
      bus_write(8'h08, 8'h70, f);
      check("R8 code 7 keeps rx", {7'd0, rx_enable}, 8'h01);

      // R1: reset in mid-run
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      #2;
      check("R1 rx_enable after reset", {7'd0, rx_enable}, 8'h00);
      check("R1 tx_valid after reset", {7'd0, tx_valid}, 8'h00);
      bus_read(8'h04, d, p);
      check("R1 status after reset", d, 8'h08);
      bus_read(8'h10, d, p);
      check("R1 mask after reset", d, 8'h00);
      bus_read(8'h00, d, p);
      check("R1 mode after reset", d, 8'h00);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule